// File: doc/BRIEF.md
# Firmware Glue Register File

This block is a small register window that firmware uses for the few system services an operating system never touches. Through a simple register bus it can stop the machine with an exit status, learn which processor is reading and how many processors are present, set the level held on any processor's interrupt line, and move single characters to and from a console.

The console side has two byte-wide streams. On the input side, reading the input status register samples the stream at that moment. If a character is waiting, it is taken and latched. On the output side, writing the output data register sends one character at once. Both status registers and both character buffers can also be overwritten by software.

The interrupt register takes a port number in its low byte and a level in its high byte. The chosen port keeps that level on its output until a later write to the same port changes it.

Top module: `fw_glue_regs`

## Requirements
- R1: A write to offset 0 pulses `haltReq` high for exactly one cycle after the write edge and loads `exitCode` with bits [7:0] of the written data.
- R2: A read of offset 4 returns `cpuId`. A read of offset 12 returns the `CPU_COUNT` parameter, or 1 when `CPU_COUNT` is 0.
- R3: A two-byte write (`busTwoByte`=1) to offset 8 selects port number data[7:0] and holds level data[15:8] on that port's byte of `intLevel` (port p occupies bits [8p+7:8p]).
- R4: A single-byte write to offset 8 drives level 0 on the selected port. Ports that are not selected keep their level, and a port number of `NUM_PORTS` or above changes no port.
- R5: When `conValid` is 1, a read of offset 20 asserts `conTake` during the request cycle, latches `conData` into the input buffer (readable at offset 16), sets the input status to 1, and returns 1.
- R6: When `conValid` is 0, a read of offset 20 leaves `conTake` low, clears both the input buffer and the input status to 0, and returns 0.
- R7: A write to offset 24 pulses `txValid` for one cycle with `txData` equal to data[7:0]. It also latches that byte for readback at offset 24 and sets the output status (offset 28) to 1.
- R8: After reset the output status reads 1, the input buffer and the output buffer read 0, `intLevel` is all zero, and neither `haltReq` nor `txValid` is asserted.
- R9: A write to offset 16 replaces the input buffer, and a write to offset 28 replaces the output status, with data[7:0].
- R10: Offsets other than 4, 12, 16, 20, 24 and 28 read as zero. Writes to offsets other than 0, 8, 16, 20, 24 and 28 change no output and no readable register.
- R11: Read data appears on `rdData`, zero-extended to 16 bits, in the cycle after the request edge, and `rdValid` is high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access request this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busTwoByte | input | 1 | Write carries two bytes (data[15:0]) rather than one |
| busAddr | input | 6 | Register offset within the window |
| busWrData | input | 16 | Write data, low byte in [7:0] |
| rdValid | output | 1 | Read data valid |
| rdData | output | 16 | Read data |
| cpuId | input | 8 | Index of the processor issuing the access |
| conValid | input | 1 | Console input has a character |
| conData | input | 8 | Console input character |
| conTake | output | 1 | Console input character consumed |
| txValid | output | 1 | Console output character strobe |
| txData | output | 8 | Console output character |
| haltReq | output | 1 | Halt request pulse |
| exitCode | output | 8 | Exit status captured by the halt write |
| intLevel | output | NUM_PORTS*8 | Per-port interrupt level |

## Verification
The assertions watch, on every cycle, properties that follow directly from the register structure. At most one write strobe is active at a time, and the interrupt levels stay unchanged whenever no interrupt write occurs. A status sample leaves the input status and buffer exactly as the console stream dictated. Every transmitted character is visible in the output buffer with the output status set. Only the bench scenarios can show that each offset returns the right value with one cycle of latency, that single-byte and out-of-range interrupt writes behave as stated, that unmapped writes touch nothing, and that software overwrites of the buffers and statuses read back.

// File: rtl/glue_pkg.sv
package glue_pkg;
  localparam int MASK_W = 6;

  localparam logic [MASK_W-1:0] OFS_HALT    = 6'd0;
  localparam logic [MASK_W-1:0] OFS_CPUID   = 6'd4;
  localparam logic [MASK_W-1:0] OFS_INT     = 6'd8;
  localparam logic [MASK_W-1:0] OFS_COUNT   = 6'd12;
  localparam logic [MASK_W-1:0] OFS_INBUF   = 6'd16;
  localparam logic [MASK_W-1:0] OFS_INSTAT  = 6'd20;
  localparam logic [MASK_W-1:0] OFS_OUTBUF  = 6'd24;
  localparam logic [MASK_W-1:0] OFS_OUTSTAT = 6'd28;

  typedef enum logic [2:0] {
    RS_ZERO, RS_CPUID, RS_COUNT, RS_INBUF, RS_INSTAT, RS_OUTBUF, RS_OUTSTAT
  } rdSel_e;

  typedef struct packed {
    logic   wrHalt;
    logic   wrInt;
    logic   wrInBuf;
    logic   wrInStat;
    logic   wrOutBuf;
    logic   wrOutStat;
    logic   rdEn;
    logic   rdSample;
    rdSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/glue_ctrl.sv
module glue_ctrl
  import glue_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [MASK_W-1:0] busAddr,
  output strobes_t          st
);
  always_comb begin
    st = '0;
    st.rdSel = RS_ZERO;
    if (busSel && busWe) begin
      unique case (busAddr)
        OFS_HALT:    st.wrHalt    = 1'b1;
        OFS_INT:     st.wrInt     = 1'b1;
        OFS_INBUF:   st.wrInBuf   = 1'b1;
        OFS_INSTAT:  st.wrInStat  = 1'b1;
        OFS_OUTBUF:  st.wrOutBuf  = 1'b1;
        OFS_OUTSTAT: st.wrOutStat = 1'b1;
        default: ;
      endcase
    end
    if (busSel && !busWe) begin
      st.rdEn = 1'b1;
      unique case (busAddr)
        OFS_CPUID:   st.rdSel = RS_CPUID;
        OFS_COUNT:   st.rdSel = RS_COUNT;
        OFS_INBUF:   st.rdSel = RS_INBUF;
        OFS_INSTAT:  begin st.rdSel = RS_INSTAT; st.rdSample = 1'b1; end
        OFS_OUTBUF:  st.rdSel = RS_OUTBUF;
        OFS_OUTSTAT: st.rdSel = RS_OUTSTAT;
        default:     st.rdSel = RS_ZERO;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.wrHalt, st.wrInt, st.wrInBuf, st.wrInStat, st.wrOutBuf, st.wrOutStat, st.rdEn})); // R10
endmodule

// File: rtl/glue_dp.sv
module glue_dp
  import glue_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CPU_COUNT = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobes_t                 st,
  input  logic                     busTwoByte,
  input  logic [15:0]              busWrData,
  input  logic [7:0]               cpuId,
  input  logic                     conValid,
  input  logic [7:0]               conData,
  output logic                     conTake,
  output logic                     rdValid,
  output logic [15:0]              rdData,
  output logic                     txValid,
  output logic [7:0]               txData,
  output logic                     haltReq,
  output logic [7:0]               exitCode,
  output logic [NUM_PORTS*8-1:0]   intLevel
);
  localparam int LEVEL_W = 8;
  localparam logic [7:0] COUNT_VAL = (CPU_COUNT == 0) ? 8'd1 : 8'(CPU_COUNT);

  logic [7:0] inBuf, inStat, outBuf, outStat;
  logic [7:0] lowByte, newLevel, rdByte;

  assign lowByte  = busWrData[7:0];
  assign newLevel = busTwoByte ? busWrData[15:8] : '0;
  assign conTake  = st.rdSample && conValid;

  // interrupt level per port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPort
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        intLevel[p*LEVEL_W +: LEVEL_W] <= '0;
      else if (st.wrInt && lowByte == 8'(p))
        intLevel[p*LEVEL_W +: LEVEL_W] <= newLevel;
    end
  end

  // halt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltReq  <= 1'b0;
      exitCode <= '0;
    end else begin
      haltReq <= st.wrHalt;
      if (st.wrHalt) exitCode <= lowByte;
    end
  end

  // console input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBuf  <= '0;
      inStat <= '0;
    end else if (st.rdSample) begin
      inBuf  <= conValid ? conData : '0;
      inStat <= conValid ? 8'd1 : '0;
    end else begin
      if (st.wrInBuf)  inBuf  <= lowByte;
      if (st.wrInStat) inStat <= lowByte;
    end
  end

  // console output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBuf  <= '0;
      outStat <= 8'd1;
      txValid <= 1'b0;
      txData  <= '0;
    end else begin
      txValid <= st.wrOutBuf;
      if (st.wrOutBuf) begin
        txData  <= lowByte;
        outBuf  <= lowByte;
        outStat <= 8'd1;
      end else if (st.wrOutStat) begin
        outStat <= lowByte;
      end
    end
  end

  // read path
  always_comb begin
    unique case (st.rdSel)
      RS_CPUID:   rdByte = cpuId;
      RS_COUNT:   rdByte = COUNT_VAL;
      RS_INBUF:   rdByte = inBuf;
      RS_INSTAT:  rdByte = conValid ? 8'd1 : 8'd0;
      RS_OUTBUF:  rdByte = outBuf;
      RS_OUTSTAT: rdByte = outStat;
      default:    rdByte = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= st.rdEn;
      if (st.rdEn) rdData <= {8'd0, rdByte};
    end
  end

  AST_INT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrInt |=> $stable(intLevel)); // R4
  AST_TX_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (outStat == 8'd1 && outBuf == txData)); // R7
  AST_SAMPLE_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdSample && conValid) |=> (inStat == 8'd1 && inBuf == $past(conData))); // R5
  AST_SAMPLE_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdSample && !conValid) |=> (inStat == 8'd0 && inBuf == 8'd0)); // R6
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !st.rdEn |=> !rdValid); // R11
endmodule

// File: rtl/fw_glue_regs.sv
module fw_glue_regs
  import glue_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CPU_COUNT = 0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busSel,
  input  logic                   busWe,
  input  logic                   busTwoByte,
  input  logic [MASK_W-1:0]      busAddr,
  input  logic [15:0]            busWrData,
  output logic                   rdValid,
  output logic [15:0]            rdData,
  input  logic [7:0]             cpuId,
  input  logic                   conValid,
  input  logic [7:0]             conData,
  output logic                   conTake,
  output logic                   txValid,
  output logic [7:0]             txData,
  output logic                   haltReq,
  output logic [7:0]             exitCode,
  output logic [NUM_PORTS*8-1:0] intLevel
);
  strobes_t st;

  glue_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .st(st)
  );

  glue_dp #(.NUM_PORTS(NUM_PORTS), .CPU_COUNT(CPU_COUNT)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .busTwoByte(busTwoByte),
    .busWrData(busWrData), .cpuId(cpuId), .conValid(conValid),
    .conData(conData), .conTake(conTake), .rdValid(rdValid),
    .rdData(rdData), .txValid(txValid), .txData(txData),
    .haltReq(haltReq), .exitCode(exitCode), .intLevel(intLevel)
  );
endmodule

// File: tb/sim_fw_glue_regs.sv
module sim_fw_glue_regs;
  localparam int NP = 4;

  logic clk = 0, rstN = 0;
  logic busSel = 0, busWe = 0, busTwoByte = 0;
  logic [5:0] busAddr = '0;
  logic [15:0] busWrData = '0;
  logic rdValid, conTake, txValid, haltReq;
  logic [15:0] rdData;
  logic [7:0] cpuId = 8'd3, conData = '0, txData, exitCode;
  logic conValid = 0;
  logic [NP*8-1:0] intLevel;

  int checks = 0, errors = 0;
  bit done = 0;

  // model
  logic [7:0] mInBuf = 0, mOutBuf = 0, mOutStat = 1;
  logic [7:0] mLvl [NP];

  always #10 clk = ~clk;

  fw_glue_regs #(.NUM_PORTS(NP), .CPU_COUNT(0)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [5:0] a);
    case (a)
      6'd4:  return cpuId;
      6'd12: return 8'd1;
      6'd16: return mInBuf;
      6'd24: return mOutBuf;
      6'd28: return mOutStat;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [NP*8-1:0] expLevels();
    logic [NP*8-1:0] v;
    for (int p = 0; p < NP; p++) v[p*8 +: 8] = mLvl[p];
    return v;
  endfunction

  task automatic doWrite(input logic [5:0] a, input logic [15:0] d, input bit two);
    @(negedge clk);
    busSel = 1; busWe = 1; busAddr = a; busWrData = d; busTwoByte = two;
    @(negedge clk);
    busSel = 0; busWe = 0; busTwoByte = 0;
    if (a == 6'd0) begin
      chk("R1 haltReq", haltReq, 1); chk("R1 exitCode", exitCode, d[7:0]);
    end else chk("R1/R10 no halt", haltReq, 0);
    if (a == 6'd24) begin
      chk("R7 txValid", txValid, 1); chk("R7 txData", txData, d[7:0]);
      mOutBuf = d[7:0]; mOutStat = 8'd1;
    end else chk("R7/R10 no tx", txValid, 0);
    if (a == 6'd16) mInBuf = d[7:0];
    if (a == 6'd28) mOutStat = d[7:0];
    if (a == 6'd8 && d[7:0] < NP) mLvl[d[7:0]] = two ? d[15:8] : 8'd0;
    chk("R3 R4 intLevel", intLevel, expLevels());
    if (a == 6'd0) begin
      @(negedge clk); chk("R1 halt one cycle", haltReq, 0);
    end
  endtask

  task automatic doRead(input logic [5:0] a);
    logic [7:0] e;
    @(negedge clk);
    busSel = 1; busWe = 0; busAddr = a;
    #1;
    if (a == 6'd20) begin
      chk(conValid ? "R5 conTake" : "R6 conTake", conTake, conValid);
      e = conValid ? 8'd1 : 8'd0;
      mInBuf = conValid ? conData : 8'd0;
    end else begin
      chk("R10 conTake idle", conTake, 0);
      e = expRead(a);
    end
    @(negedge clk);
    busSel = 0;
    chk("R11 rdValid", rdValid, 1);
    chk("R2 R5 R6 R9 R10 rdData", rdData, {8'd0, e});
    @(negedge clk);
    chk("R11 rdValid drops", rdValid, 0);
  endtask

  initial begin
    for (int i = 0; i < 5000; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int p = 0; p < NP; p++) mLvl[p] = 8'd0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R8 reset state
    chk("R8 intLevel", intLevel, 0);
    chk("R8 haltReq", haltReq, 0);
    chk("R8 txValid", txValid, 0);
    doRead(6'd28); doRead(6'd16); doRead(6'd24);
    // R2
    doRead(6'd4); cpuId = 8'd7; doRead(6'd4); doRead(6'd12);
    // R1
    doWrite(6'd0, 16'h12A5, 0);
    // R3 / R4
    doWrite(6'd8, 16'h5A02, 1);
    doWrite(6'd8, 16'h3301, 1);
    doWrite(6'd8, 16'h7702, 0);
    doWrite(6'd8, 16'hEE04, 1);
    doWrite(6'd8, 16'hEEFF, 1);
    // R5 / R6
    conValid = 1; conData = 8'h41; doRead(6'd20); conValid = 0; doRead(6'd16);
    doRead(6'd20); doRead(6'd16);
    // R7 / R9
    doWrite(6'd24, 16'h0063, 0); doRead(6'd24); doRead(6'd28);
    doWrite(6'd28, 16'h0000, 0); doRead(6'd28);
    doWrite(6'd16, 16'h00C3, 0); doRead(6'd16);
    // R10 unmapped
    doWrite(6'd36, 16'hFFFF, 1); doWrite(6'd4, 16'h00AA, 0); doWrite(6'd12, 16'h0099, 0);
    doRead(6'd36); doRead(6'd0); doRead(6'd8); doRead(6'd63);
    doRead(6'd16); doRead(6'd24); doRead(6'd28);
    // random mix
    for (int k = 0; k < 300; k++) begin
      int unsigned op = $urandom_range(0, 5);
      logic [5:0] a = 6'($urandom_range(0, 15) * 4);
      logic [15:0] d = 16'($urandom());
      case (op)
        0: doWrite(6'd8, {d[15:8], 8'($urandom_range(0, NP + 1))}, 1'($urandom_range(0, 1)));
        1: begin conValid = 1'($urandom_range(0, 1)); conData = d[7:0]; doRead(6'd20); conValid = 0; end
        2: doWrite(6'd24, d, 0);
        3: if (a != 6'd0) doWrite(a, d, 1'($urandom_range(0, 1)));
        default: doRead(a);
      endcase
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule